// File: doc/BRIEF.md
# Dual-Width Timer with Atomic High-Byte Access

This block is a free-running timer/counter on a simple byte-wide register bus. It counts either the system clock or edges of an external pin, optionally through a power-of-two prescaler. It can run as an 8-bit or a 16-bit counter, and it raises a sticky overflow flag whenever the count wraps to zero. The flag, gated by an enable bit, drives an interrupt request. A sleep input freezes counting, so no overflow can occur while it is asserted.

In 16-bit mode software never touches the upper counter byte directly. Reading the low byte captures the upper byte into a holding buffer in the same access. Writing the low byte loads the upper byte from that buffer in the same cycle. A 16-bit value is therefore read or written as one coherent snapshot, even while the timer runs.

Top module: `dwt_timer`

## Requirements
- R1: After synchronous reset the control register reads 0xFF, the flag register reads 0x00 and `irq` is low. The counter bytes and the holding buffer are not initialised.
- R2: Register codes on `bus_sel`: 0 = control, 1 = low counter byte, 2 = high holding buffer, 3 = flag register (bit 0 overflow flag, bit 1 interrupt enable). Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`.
- R3: The control byte holds: bit 7 run, bit 6 width (1 = 8-bit, 0 = 16-bit), bit 5 source (1 = external pin), bit 4 pin edge (0 = rising, 1 = falling), bit 3 prescaler bypass, bits 2:0 ratio code.
- R4: With run set, internal source and bypass set, the counter advances by one every clock cycle.
- R5: With bypass clear, ratio code n makes the counter advance once per 2^(n+1) source ticks (1:2 up to 1:256).
- R6: A write to the low byte clears the prescaler, and the counter ignores the first two source ticks after the write.
- R7: In 8-bit mode a count from 0xFF to 0x00 sets the overflow flag and leaves the high counter byte unchanged.
- R8: In 16-bit mode a count from 0xFFFF to 0x0000 sets the overflow flag.
- R9: Each read of the low byte copies the high counter byte into the holding buffer. A read of code 2 returns the buffer.
- R10: A write to code 2 loads only the buffer. A write to the low byte loads the low counter byte and copies the buffer into the high counter byte in the same cycle.
- R11: Hardware only sets the overflow flag. Writing 0 to flag bit 0 clears it, and writing 1 leaves it unchanged.
- R12: `irq` is high exactly when the flag and the enable are both set. Clearing the enable leaves the flag as it was.
- R13: While `sleep` is high the counter holds its value.
- R14: With the external source selected, `ext_pin` passes through a two-flop synchroniser, and only the edge chosen by the edge bit counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register code |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| sleep | input | 1 | Halts counting while high |
| ext_pin | input | 1 | Asynchronous external count source |
| irq | output | 1 | Interrupt request |

## Verification
The bench reads the counter at exact cycle offsets after a low-byte write. This catches a design that lacks the two-tick hold after the write or that leaves the prescaler uncleared, since either one shifts the count by a few units. It interleaves buffer writes and low-byte reads. A design that exposes the live high byte, or that commits the buffer on the high write, then returns the wrong byte from code 2. The overflow cases check the 8-bit wrap with a distinct high byte. That byte would be corrupted if the carry ran through in 8-bit mode. Other cases write 1 to the flag, mask the interrupt, hold the timer in sleep, and count pin pulses in both edge modes while the first two pulses are dropped.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LOW  = 2'd1,
    REG_HIGH = 2'd2,
    REG_FLAG = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       run;
    logic       narrow;
    logic       ext_src;
    logic       fall_edge;
    logic       no_presc;
    logic [2:0] ratio;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = 8'hFF;

endpackage

// File: rtl/dwt_edge_sync.sv
module dwt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_pulse
);

  logic [STAGES-1:0] chain;
  logic              prev;
  logic              cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign cur        = chain[STAGES-1];
  assign edge_pulse = fall_sel ? (prev & ~cur) : (~prev & cur);

endmodule

// File: rtl/dwt_prescaler.sv
module dwt_prescaler #(
  parameter int RATIO_W    = 3,
  parameter int HOLD_TICKS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_in,
  input  logic               clear,
  input  logic               bypass,
  input  logic [RATIO_W-1:0] ratio,
  output logic               count_en
);

  localparam int PRESC_W = 2 ** RATIO_W;
  localparam int HOLD_W  = $clog2(HOLD_TICKS + 1);
  localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(HOLD_TICKS);

  logic [PRESC_W-1:0] pcnt;
  logic [PRESC_W-1:0] mask;
  logic [HOLD_W-1:0]  hold;
  logic               holding;
  logic               div_hit;

  always_comb begin
    for (int i = 0; i < PRESC_W; i++) begin
      mask[i] = (i <= int'(ratio));
    end
  end

  assign holding  = (hold != '0);
  assign div_hit  = &(pcnt | ~mask);
  assign count_en = tick_in & ~clear & ~holding & (bypass | div_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
      hold <= '0;
    end else if (clear) begin
      pcnt <= '0;
      hold <= HOLD_INIT;
    end else if (tick_in) begin
      if (holding) begin
        hold <= hold - 1'b1;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dwt_counter.sv
module dwt_counter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              cnt_en,
  input  logic              narrow,
  input  logic              wr_low,
  input  logic              wr_high,
  input  logic              rd_low,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic [BYTE_W-1:0] hi_buf,
  output logic              wrap
);

  logic [2*BYTE_W-1:0] wide_next;

  assign wide_next = {cnt_hi, cnt_lo} + 1'b1;
  assign wrap      = cnt_en & ~wr_low & (&cnt_lo) & (narrow | (&cnt_hi));

  always_ff @(posedge clk) begin
    if (wr_low) begin
      cnt_lo <= wdata;
      cnt_hi <= hi_buf;
    end else if (cnt_en) begin
      if (narrow) begin
        cnt_lo <= cnt_lo + 1'b1;
      end else begin
        {cnt_hi, cnt_lo} <= wide_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_high) begin
      hi_buf <= wdata;
    end else if (rd_low) begin
      hi_buf <= cnt_hi;
    end
  end

endmodule

// File: rtl/dwt_timer.sv
module dwt_timer
  import dwt_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              sleep,
  input  logic              ext_pin,
  output logic              irq
);

  localparam int RATIO_W = 3;

  ctrl_t             ctrl;
  logic              ovf_flag;
  logic              irq_en;
  logic              wr_ctrl, wr_low, wr_high, wr_flag, rd_low;
  logic              pin_edge;
  logic              src_tick;
  logic              gated_tick;
  logic              count_en;
  logic              wrap;
  logic [BYTE_W-1:0] cnt_lo, cnt_hi, hi_buf;

  assign wr_ctrl = bus_wr && (reg_sel_e'(bus_sel) == REG_CTRL);
  assign wr_low  = bus_wr && (reg_sel_e'(bus_sel) == REG_LOW);
  assign wr_high = bus_wr && (reg_sel_e'(bus_sel) == REG_HIGH);
  assign wr_flag = bus_wr && (reg_sel_e'(bus_sel) == REG_FLAG);
  assign rd_low  = bus_rd && (reg_sel_e'(bus_sel) == REG_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= CTRL_RESET;
    end else if (wr_ctrl) begin
      ctrl <= ctrl_t'(bus_wdata[7:0]);
    end
  end

  dwt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pin       (ext_pin),
    .fall_sel  (ctrl.fall_edge),
    .edge_pulse(pin_edge)
  );

  assign src_tick   = ctrl.ext_src ? pin_edge : 1'b1;
  assign gated_tick = ctrl.run & ~sleep & src_tick;

  dwt_prescaler #(.RATIO_W(RATIO_W), .HOLD_TICKS(HOLD_TICKS)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .tick_in (gated_tick),
    .clear   (wr_low),
    .bypass  (ctrl.no_presc),
    .ratio   (ctrl.ratio),
    .count_en(count_en)
  );

  dwt_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk    (clk),
    .cnt_en (count_en),
    .narrow (ctrl.narrow),
    .wr_low (wr_low),
    .wr_high(wr_high),
    .rd_low (rd_low),
    .wdata  (bus_wdata),
    .cnt_lo (cnt_lo),
    .cnt_hi (cnt_hi),
    .hi_buf (hi_buf),
    .wrap   (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      irq_en   <= 1'b0;
    end else begin
      if (wrap) begin
        ovf_flag <= 1'b1;
      end else if (wr_flag && !bus_wdata[0]) begin
        ovf_flag <= 1'b0;
      end
      if (wr_flag) begin
        irq_en <= bus_wdata[1];
      end
    end
  end

  assign irq = ovf_flag & irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        unique case (reg_sel_e'(bus_sel))
          REG_CTRL: bus_rdata <= BYTE_W'(ctrl);
          REG_LOW:  bus_rdata <= cnt_lo;
          REG_HIGH: bus_rdata <= hi_buf;
          REG_FLAG: bus_rdata <= BYTE_W'({irq_en, ovf_flag});
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/dwt_timer_chk.sv
module dwt_timer_chk
  import dwt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        bus_sel,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              bus_rvalid,
  input logic              sleep,
  input logic              narrow,
  input logic              ovf_flag,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic [BYTE_W-1:0] hi_buf
);

  logic wl, wh, rl, wf;
  assign wl = bus_wr && (bus_sel == 2'(REG_LOW));
  assign wh = bus_wr && (bus_sel == 2'(REG_HIGH));
  assign rl = bus_rd && (bus_sel == 2'(REG_LOW));
  assign wf = bus_wr && (bus_sel == 2'(REG_FLAG));

  // R2
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  // R10
  low_commit_chk: assert property (@(posedge clk) disable iff (rst)
    wl |=> (cnt_lo == $past(bus_wdata)) && (cnt_hi == $past(hi_buf)));

  // R9
  low_read_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (rl && !wh) |=> (hi_buf == $past(cnt_hi)));

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_flag) |-> $past(wf && !bus_wdata[0]));

  // R11
  flag_write_one_chk: assert property (@(posedge clk) disable iff (rst)
    (wf && bus_wdata[0] && ovf_flag) |=> ovf_flag);

  // R13
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(sleep) && !$past(wl)) |-> ((cnt_lo == $past(cnt_lo)) && (cnt_hi == $past(cnt_hi))));

  // R6
  hold_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wl, 2) && !$past(wl)) |-> (cnt_lo == $past(bus_wdata, 2)));

  // R7
  narrow_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(narrow) && !$past(wl) && ($past(cnt_lo) == '1) && (cnt_lo == '0)) |-> ovf_flag);

endmodule

bind dwt_timer dwt_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rvalid(bus_rvalid),
  .sleep     (sleep),
  .narrow    (ctrl.narrow),
  .ovf_flag  (ovf_flag),
  .cnt_lo    (cnt_lo),
  .cnt_hi    (cnt_hi),
  .hi_buf    (hi_buf)
);

// File: tb/tb_dwt_timer.sv
`timescale 1ns/1ps
module tb_dwt_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic       sleep = 1'b0;
  logic       ext_pin = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_wr = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  dwt_timer dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .sleep(sleep), .ext_pin(ext_pin), .irq(irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected rvalid", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = a; bus_wdata = d; bus_wr = 1'b1;
    last_wr = cyc + 1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_sel = a; bus_rd = 1'b1;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // low-byte read at a known cycle distance from the low write at edge t0
  task automatic rd_cnt(input int t0, input int w, input int div, input string tag);
    item_t it;
    int r, n;
    @(negedge clk);
    r = cyc + 1;
    n = (r - t0 - 3 > 0) ? (r - t0 - 3) / div : 0;
    bus_sel = 2'd1; bus_rd = 1'b1;
    it.exp = 8'((w + n) & 8'hFF); it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_pin = 1'b1;
      idle(4);
      ext_pin = 1'b0;
      idle(4);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int t, s;
    idle(4);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check(irq === 1'b0, "R1 irq after reset", irq, 0);
    rd(2'd0, 8'hFF, "R1 ctrl reset");
    rd(2'd3, 8'h00, "R1 flag reset");

    // R2 R3 R9 R10 atomic access with the timer stopped
    wr(2'd0, 8'h08);
    rd(2'd0, 8'h08, "R3 ctrl readback");
    wr(2'd2, 8'h12);
    wr(2'd1, 8'h34);
    rd(2'd2, 8'h12, "R10 buffer after write");
    wr(2'd2, 8'h56);
    rd(2'd2, 8'h56, "R10 high write hits buffer only");
    rd(2'd1, 8'h34, "R2 low byte read");
    rd(2'd2, 8'h12, "R9 low read latches high");

    // R4 R6 counting with hold after low write
    wr(2'd0, 8'h88);
    wr(2'd1, 8'h77); t = last_wr;
    rd_cnt(t, 8'h77, 1, "R6 hold tick one");
    rd_cnt(t, 8'h77, 1, "R6 first count after hold");
    wr(2'd1, 8'h10); t = last_wr;
    idle(18);
    rd_cnt(t, 8'h10, 1, "R4 count every clock");

    // R5 prescaler
    wr(2'd0, 8'h82);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00); t = last_wr;
    idle(45);
    rd_cnt(t, 0, 8, "R5 divide by 8");
    wr(2'd0, 8'h87);
    wr(2'd1, 8'h00); t = last_wr;
    idle(700);
    rd_cnt(t, 0, 256, "R5 divide by 256");
    rd(2'd2, 8'h00, "R5 high byte after slow count");

    // R7 8-bit overflow, high byte held
    wr(2'd0, 8'hC8);
    wr(2'd2, 8'h5A);
    wr(2'd1, 8'hFE); t = last_wr;
    idle(6);
    wr(2'd0, 8'h48); s = last_wr;
    rd(2'd3, 8'h01, "R7 flag on 8-bit wrap");
    rd(2'd1, 8'((8'hFE + s - t - 2) & 8'hFF), "R7 low byte after wrap");
    rd(2'd2, 8'h5A, "R7 high byte untouched");

    // R11 R12 flag and interrupt
    check(irq === 1'b0, "R12 irq masked", irq, 0);
    wr(2'd3, 8'h03);
    check(irq === 1'b1, "R12 irq with enable", irq, 1);
    rd(2'd3, 8'h03, "R11 write one keeps flag");
    wr(2'd3, 8'h01);
    check(irq === 1'b0, "R12 irq after mask", irq, 0);
    rd(2'd3, 8'h01, "R12 mask keeps flag");
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h00, "R11 write zero clears");

    // R8 16-bit overflow
    wr(2'd0, 8'h88);
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'hFE); t = last_wr;
    idle(6);
    wr(2'd0, 8'h08); s = last_wr;
    rd(2'd3, 8'h01, "R8 flag on 16-bit wrap");
    rd(2'd1, 8'((8'hFE + s - t - 2) & 8'hFF), "R8 low after wrap");
    rd(2'd2, 8'h00, "R8 high after wrap");
    wr(2'd3, 8'h00);

    // R13 sleep
    wr(2'd0, 8'h88);
    @(negedge clk); sleep = 1'b1;
    wr(2'd1, 8'h40);
    idle(20);
    rd(2'd1, 8'h40, "R13 frozen in sleep");
    rd(2'd3, 8'h00, "R13 no overflow in sleep");
    @(negedge clk); sleep = 1'b0;

    // R14 external pin, both edges
    wr(2'd0, 8'hA8);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    pulses(5);
    idle(10);
    rd(2'd1, 8'h03, "R14 rising edges");
    wr(2'd0, 8'hB8);
    wr(2'd1, 8'h00);
    pulses(5);
    idle(10);
    rd(2'd1, 8'h03, "R14 falling edges");

    idle(4);
    check(sb.size() == 0, "R2 missing read data", sb.size(), 0);
    finish_run();
  end

endmodule